// File: doc/BRIEF.md
# Parallel UART Register Bus Master

This block carries out one register access at a time on an 8-bit asynchronous parallel bus that connects to a four-channel UART device. A requester presents a channel number, a 3-bit register index, a direction flag and, for writes, a data byte. It holds `reqValid` high until the block accepts the request, which happens while `ready` is high. The block then runs a fixed pin sequence. The addressed channel's select goes low first. The read or write strobe follows after one wait phase. One wait phase after the strobe returns high, the select is released. Every wait phase lasts `WAIT_CYCLES` clock cycles.

The board routes both the address lines and the data lines in reversed bit order. The block therefore mirrors every address and every data byte: on the way out for writes, and on the way in for reads. The bidirectional data pins appear as separate out, in and output-enable signals. The output enable is active only while the select of a write is low, so the bus floats at all other times.

Two plain register outputs drive the device's power enable and its active-high reset. A separate control strobe loads both of them.

Top module: `uartBusMaster`

## Requirements
- R1: After reset all four `csN` bits, `rdN` and `wrN` are 1. `dataOe`, `done`, `devReset` and `powerEn` are 0, and `ready` is 1.
- R2: During an access to channel n, only bit n of `csN` is 0. It goes low on the clock edge that accepts the request, and at most one `csN` bit is ever 0.
- R3: Logical address bit i appears on `addrPin[2-i]`, so logical 1 gives pin pattern 4 and logical 3 gives 6. `addrPin` does not change while a select is low.
- R4: In a write, `wrN` goes low WAIT_CYCLES cycles after the select falls and stays low for WAIT_CYCLES cycles. The select rises WAIT_CYCLES cycles after `wrN` rises. `rdN` stays 1 throughout.
- R5: In a write, `dataOe` is 1 for as long as the select is low. Logical data bit i appears on `dataOut[7-i]`.
- R6: In a read, `dataOe` stays 0. `rdN` goes low WAIT_CYCLES cycles after the select falls and stays low for 2*WAIT_CYCLES cycles. The select rises WAIT_CYCLES cycles after `rdN` rises.
- R7: In a read, `dataIn` is sampled on the edge that ends the first WAIT_CYCLES cycles of `rdN` low. `rdData` bit i is `dataIn[7-i]` of that sample.
- R8: `dataOe` returns to 0 on the same edge that releases the select of an access.
- R9: `done` is a one-cycle pulse in the cycle right after the select is released. `rdData` is valid during that cycle. `ready` is 1 only when no access is running.
- R10: A request presented while `ready` is 0 is ignored. It changes no pin and starts no access.
- R11: `rdN` and `wrN` are never 0 at the same time. Neither is ever 0 unless a select is 0.
- R12: When `ctrlValid` is 1, `devReset` and `powerEn` load `ctrlDevReset` and `ctrlPower` on the next edge. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request present |
| reqChan | input | 2 | Target channel 0..3 |
| reqAddr | input | 3 | Logical register index |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 8 | Logical write byte |
| ready | output | 1 | Idle, request can be accepted |
| done | output | 1 | Access finished (one cycle) |
| rdData | output | 8 | Logical read byte |
| ctrlValid | input | 1 | Load power/reset registers |
| ctrlDevReset | input | 1 | Value for devReset |
| ctrlPower | input | 1 | Value for powerEn |
| csN | output | 4 | Active-low channel selects |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| addrPin | output | 3 | Reversed address pins |
| dataOut | output | 8 | Reversed data driven to pins |
| dataIn | input | 8 | Data pins as received |
| dataOe | output | 1 | Data pin output enable |
| devReset | output | 1 | Device reset level |
| powerEn | output | 1 | Device power enable |

## Verification
The bench counts cycles from the accepting edge to each strobe edge, to the select release and to `done`. A design that checks its wait counter against the wrong value, or that skips the read hold phase, produces strobes that are one phase short or long. The bench uses asymmetric address and data patterns so that an unreversed or half-reversed mapping shows up as wrong pins or wrong read data. It also presents a second request in the middle of an access to catch a design that restarts or switches selects. Finally, it checks that the output enable is off during reads and after every write, because an enable left on would drive against the device.

// File: rtl/uartBusPkg.sv
package uartBusPkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_STROBE  = 3'd2,
    ST_HOLD    = 3'd3,
    ST_RELEASE = 3'd4
  } busState_t;

  // control-to-datapath strobes, each a single-cycle event
  typedef struct packed {
    logic launch;     // latch request, drop select, set address/data
    logic strobeOn;   // pull read or write strobe low
    logic sample;     // capture read data
    logic strobeOff;  // return strobes high
    logic finish;     // release select, float bus
  } busStrobes_t;

endpackage

// File: rtl/uartBusCtrl.sv
module uartBusCtrl
  import uartBusPkg::*;
#(
  parameter int WAIT_CYCLES = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  output logic        ready,
  output logic        done,
  output busStrobes_t strb
);

  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  busState_t state;
  logic [CNT_W-1:0] phaseCnt;
  logic isRead;
  logic phaseEnd;

  assign ready    = (state == ST_IDLE);
  assign phaseEnd = (phaseCnt == LAST);

  always_comb begin
    strb           = '0;
    strb.launch    = ready && reqValid;
    strb.strobeOn  = (state == ST_SETUP) && phaseEnd;
    strb.sample    = (state == ST_STROBE) && phaseEnd && isRead;
    strb.strobeOff = ((state == ST_STROBE) && phaseEnd && !isRead) ||
                     ((state == ST_HOLD) && phaseEnd);
    strb.finish    = (state == ST_RELEASE) && phaseEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      isRead   <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= strb.finish;
      if (state == ST_IDLE) begin
        phaseCnt <= '0;
        if (reqValid) begin
          state  <= ST_SETUP;
          isRead <= !reqWrite;
        end
      end else if (!phaseEnd) begin
        phaseCnt <= phaseCnt + 1'b1;
      end else begin
        phaseCnt <= '0;
        case (state)
          ST_SETUP:   state <= ST_STROBE;
          ST_STROBE:  state <= isRead ? ST_HOLD : ST_RELEASE;
          ST_HOLD:    state <= ST_RELEASE;
          default:    state <= ST_IDLE;
        endcase
      end
    end
  end

  // R9: done lasts a single cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10: a busy block does not launch
  a_r10_no_launch_busy: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_IDLE) |-> !strb.launch);

endmodule

// File: rtl/uartBusDatapath.sv
module uartBusDatapath
  import uartBusPkg::*;
#(
  parameter int CHANNELS = 4,
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  busStrobes_t                 strb,
  input  logic [$clog2(CHANNELS)-1:0] reqChan,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic                        reqWrite,
  input  logic [DATA_W-1:0]           reqWdata,
  input  logic                        ctrlValid,
  input  logic                        ctrlDevReset,
  input  logic                        ctrlPower,
  input  logic [DATA_W-1:0]           dataIn,
  output logic [CHANNELS-1:0]         csN,
  output logic                        rdN,
  output logic                        wrN,
  output logic [ADDR_W-1:0]           addrPin,
  output logic [DATA_W-1:0]           dataOut,
  output logic                        dataOe,
  output logic [DATA_W-1:0]           rdData,
  output logic                        devReset,
  output logic                        powerEn
);

  logic [ADDR_W-1:0] addrMirror;
  logic [DATA_W-1:0] wdataMirror;
  logic [DATA_W-1:0] rdataMirror;
  logic              isWrite;

  // board wiring reverses bit order on both buses
  for (genvar i = 0; i < ADDR_W; i++) begin : gAddrRev
    assign addrMirror[i] = reqAddr[ADDR_W-1-i];
  end
  for (genvar i = 0; i < DATA_W; i++) begin : gDataRev
    assign wdataMirror[i] = reqWdata[DATA_W-1-i];
    assign rdataMirror[i] = dataIn[DATA_W-1-i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csN     <= '1;
      rdN     <= 1'b1;
      wrN     <= 1'b1;
      addrPin <= '0;
      dataOut <= '0;
      dataOe  <= 1'b0;
      rdData  <= '0;
      isWrite <= 1'b0;
    end else begin
      if (strb.launch) begin
        addrPin <= addrMirror;
        dataOut <= reqWrite ? wdataMirror : '0;
        dataOe  <= reqWrite;
        isWrite <= reqWrite;
        csN     <= ~(CHANNELS'(1) << reqChan);
      end
      if (strb.strobeOn) begin
        if (isWrite) wrN <= 1'b0;
        else         rdN <= 1'b0;
      end
      if (strb.sample)    rdData <= rdataMirror;
      if (strb.strobeOff) begin
        rdN <= 1'b1;
        wrN <= 1'b1;
      end
      if (strb.finish) begin
        csN    <= '1;
        dataOe <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devReset <= 1'b0;
      powerEn  <= 1'b0;
    end else if (ctrlValid) begin
      devReset <= ctrlDevReset;
      powerEn  <= ctrlPower;
    end
  end

  // R2: never two selects at once
  a_r2_single_select: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R11: strobes exclusive and only inside a select
  a_r11_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  a_r11_strobe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !(&csN));

  // R3: address steady while a select stays low
  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!(&csN) && $past(!(&csN))) |-> $stable(addrPin));

  // R6: bus is never driven while reading
  a_r6_no_drive_read: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !dataOe);

  // R8: enable off whenever no select is active
  a_r8_float_idle: assert property (@(posedge clk) disable iff (!rstN)
    (&csN) |-> !dataOe);

endmodule

// File: rtl/uartBusMaster.sv
module uartBusMaster
  import uartBusPkg::*;
#(
  parameter int WAIT_CYCLES = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqChan,
  input  logic [2:0] reqAddr,
  input  logic       reqWrite,
  input  logic [7:0] reqWdata,
  output logic       ready,
  output logic       done,
  output logic [7:0] rdData,
  input  logic       ctrlValid,
  input  logic       ctrlDevReset,
  input  logic       ctrlPower,
  output logic [3:0] csN,
  output logic       rdN,
  output logic       wrN,
  output logic [2:0] addrPin,
  output logic [7:0] dataOut,
  input  logic [7:0] dataIn,
  output logic       dataOe,
  output logic       devReset,
  output logic       powerEn
);

  busStrobes_t strb;

  uartBusCtrl #(.WAIT_CYCLES(WAIT_CYCLES)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .ready    (ready),
    .done     (done),
    .strb     (strb)
  );

  uartBusDatapath #(.CHANNELS(4), .ADDR_W(3), .DATA_W(8)) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqChan      (reqChan),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .reqWdata     (reqWdata),
    .ctrlValid    (ctrlValid),
    .ctrlDevReset (ctrlDevReset),
    .ctrlPower    (ctrlPower),
    .dataIn       (dataIn),
    .csN          (csN),
    .rdN          (rdN),
    .wrN          (wrN),
    .addrPin      (addrPin),
    .dataOut      (dataOut),
    .dataOe       (dataOe),
    .rdData       (rdData),
    .devReset     (devReset),
    .powerEn      (powerEn)
  );

  // R9: done comes only after every select is released
  a_r9_done_released: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (&csN && rdN && wrN));

endmodule

// File: tb/uartBusMaster_test.sv
module uartBusMaster_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqChan = '0;
  logic [2:0] reqAddr = '0;
  logic       reqWrite = 1'b0;
  logic [7:0] reqWdata = '0;
  logic       ctrlValid = 1'b0;
  logic       ctrlDevReset = 1'b0;
  logic       ctrlPower = 1'b0;
  logic [7:0] devPins = '0;
  logic       ready, done, rdN, wrN, dataOe, devReset, powerEn;
  logic [7:0] rdData, dataOut, dataIn;
  logic [3:0] csN;
  logic [2:0] addrPin;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // device model: drives pins only while read strobe and a select are low
  assign dataIn = (!rdN && !(&csN)) ? devPins : 8'h00;

  uartBusMaster #(.WAIT_CYCLES(W)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqChan(reqChan),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .ready(ready), .done(done), .rdData(rdData), .ctrlValid(ctrlValid),
    .ctrlDevReset(ctrlDevReset), .ctrlPower(ctrlPower), .csN(csN),
    .rdN(rdN), .wrN(wrN), .addrPin(addrPin), .dataOut(dataOut),
    .dataIn(dataIn), .dataOe(dataOe), .devReset(devReset), .powerEn(powerEn)
  );

  function automatic logic [7:0] mirror8(input logic [7:0] x);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = x[7-i];
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // present a request for one edge, then trace pins at negedges
  task automatic runAccess(input logic [1:0] ch, input logic [2:0] ad,
                           input logic wr, input logic [7:0] wd,
                           input bit poke, output int tStrobeLo,
                           output int tStrobeHi, output int tCsHi,
                           output int tDone, output bit oeBad,
                           output bit csBad, output bit pinBad);
    @(negedge clk);
    reqValid = 1'b1; reqChan = ch; reqAddr = ad; reqWrite = wr; reqWdata = wd;
    @(posedge clk); #1;
    reqValid = 1'b0;
    tStrobeLo = -1; tStrobeHi = -1; tCsHi = -1; tDone = -1;
    oeBad = 0; csBad = 0; pinBad = 0;
    for (int k = 1; k < 40; k++) begin
      @(negedge clk);
      if (poke && k == 2) begin
        reqValid = 1'b1; reqChan = ch + 2'd1; reqAddr = ~ad; reqWrite = ~wr; reqWdata = ~wd;
      end
      if (poke && k == 4) reqValid = 1'b0;
      if (!(&csN)) begin
        if (csN != ~(4'b1 << ch)) csBad = 1;
        if (dataOe != wr) oeBad = 1;
        if (addrPin != {ad[0], ad[1], ad[2]}) pinBad = 1;
        if (wr && dataOut != mirror8(wd)) pinBad = 1;
        if (wr ? !rdN : !wrN) pinBad = 1;
      end else if (tCsHi < 0) begin
        tCsHi = k;
        if (dataOe) oeBad = 1;
      end
      if ((wr ? wrN : rdN) == 1'b0 && tStrobeLo < 0) tStrobeLo = k;
      if (tStrobeLo >= 0 && tStrobeHi < 0 && (wr ? wrN : rdN)) tStrobeHi = k;
      if (done && tDone < 0) tDone = k;
      if (tDone >= 0 && k > tDone + 3) break;
    end
  endtask

  task automatic testReset();
    check(csN == 4'hF, "R1 csN", csN, 4'hF);
    check(rdN && wrN, "R1 strobes", {rdN, wrN}, 2'b11);
    check(!dataOe, "R1 dataOe", dataOe, 0);
    check(ready && !done, "R1 ready/done", {ready, done}, 2'b10);
    check(!devReset && !powerEn, "R1 power/reset", {devReset, powerEn}, 0);
  endtask

  task automatic testWrite(input logic [1:0] ch, input logic [2:0] ad, input logic [7:0] wd);
    int lo, hi, ce, dn; bit oe, cs, pin;
    runAccess(ch, ad, 1'b1, wd, 0, lo, hi, ce, dn, oe, cs, pin);
    check(!cs, "R2 write select", ch, ch);
    check(!pin, "R3/R5 write pins", addrPin, ad);
    check(lo == W + 1, "R4 wrN fall", lo, W + 1);
    check(hi == 2*W + 1, "R4 wrN rise", hi, 2*W + 1);
    check(ce == 3*W + 1, "R4 cs release", ce, 3*W + 1);
    check(!oe, "R5 R8 write enable", oe, 0);
    check(dn == 3*W + 1, "R9 write done", dn, 3*W + 1);
  endtask

  task automatic testRead(input logic [1:0] ch, input logic [2:0] ad, input logic [7:0] val);
    int lo, hi, ce, dn; bit oe, cs, pin;
    devPins = mirror8(val);
    runAccess(ch, ad, 1'b0, 8'h00, 0, lo, hi, ce, dn, oe, cs, pin);
    check(!cs, "R2 read select", ch, ch);
    check(!pin, "R3 read pins", addrPin, ad);
    check(!oe, "R6 no drive", oe, 0);
    check(lo == W + 1, "R6 rdN fall", lo, W + 1);
    check(hi == 3*W + 1, "R6 rdN rise", hi, 3*W + 1);
    check(ce == 4*W + 1, "R6 cs release", ce, 4*W + 1);
    check(dn == 4*W + 1, "R9 read done", dn, 4*W + 1);
    check(rdData == val, "R7 read data", rdData, val);
  endtask

  task automatic testBusyIgnored();
    int lo, hi, ce, dn; bit oe, cs, pin;
    runAccess(2'd1, 3'd3, 1'b1, 8'h2D, 1, lo, hi, ce, dn, oe, cs, pin);
    check(!cs && !pin, "R10 pins kept during busy request", csN, 4'hF);
    check(ce == 3*W + 1, "R10 timing kept", ce, 3*W + 1);
    @(negedge clk);
    check(csN == 4'hF && ready, "R10 no second access", csN, 4'hF);
  endtask

  task automatic testCtrl();
    @(negedge clk);
    ctrlValid = 1'b1; ctrlDevReset = 1'b1; ctrlPower = 1'b1;
    @(negedge clk);
    ctrlValid = 1'b0; ctrlDevReset = 1'b0; ctrlPower = 1'b0;
    check(devReset && powerEn, "R12 load", {devReset, powerEn}, 2'b11);
    @(negedge clk);
    check(devReset && powerEn, "R12 hold", {devReset, powerEn}, 2'b11);
    ctrlValid = 1'b1; ctrlDevReset = 1'b0; ctrlPower = 1'b1;
    @(negedge clk);
    ctrlValid = 1'b0;
    check(!devReset && powerEn, "R12 reload", {devReset, powerEn}, 2'b01);
  endtask

  task automatic testAddrMap();
    int lo, hi, ce, dn; bit oe, cs, pin;
    runAccess(2'd0, 3'd1, 1'b1, 8'h01, 0, lo, hi, ce, dn, oe, cs, pin);
    check(!pin, "R3 addr 1 gives pins 4", 3'd4, 3'd4);
    runAccess(2'd0, 3'd3, 1'b1, 8'h01, 0, lo, hi, ce, dn, oe, cs, pin);
    check(!pin, "R3 addr 3 gives pins 6", 3'd6, 3'd6);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*2 + 2);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testWrite(2'd0, 3'd1, 8'h01);
    testWrite(2'd3, 3'd6, 8'hC5);
    testWrite(2'd2, 3'd7, 8'hF0);
    testRead(2'd1, 3'd5, 8'h81);
    testRead(2'd3, 3'd2, 8'h3A);
    testRead(2'd0, 3'd0, 8'hFE);
    testAddrMap();
    testBusyIgnored();
    testCtrl();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule